// File: doc/BRIEF.md
# Lockable Comparator Control Register File

This block holds the configuration words for a set of analog comparator channels (two by default) behind a simple single-cycle register interface. Each channel owns one 32-bit word at a word-aligned offset (channel 0 at 0x00, channel 1 at 0x04). The word carries the enable, the power/speed mode, the plus and minus input selects, the hysteresis and blanking-source selects, the output polarity and, on the second channel only, a window-mode flag that ties the two plus inputs together. Bit 30 of every word reads back the live comparator result after polarity inversion.

The stored fields drive configuration outputs towards the analog side. The minus-input select is turned into one resolved source code per channel. That code takes the extended pin select into account, and it redirects a fractional reference request to the full reference when the shared scaler runs without its divider bridge. The scaler and bridge enables are shared: each is on when any channel asks for it.

Each word has a set-only write-protect bit. Once it is set, the whole word, the protect bit included, ignores every write until a synchronous system reset. Reads keep working.

Top module: `cmp_ctl_regs`

## Requirements
- R1: Writing a word with bit 31 = 1 locks it. After that, every write to that word is ignored with no error indication, reads still return its contents, and the other words remain writable.
- R2: A locked word unlocks only through reset (rst_n low at a clock edge). A later write of 0 to bit 31 does not clear it.
- R3: Bit 30 of a read word and cmp_value[ch] both equal cmp_raw[ch] XOR polarity (bit 15). Writes to bit 30 have no effect.
- R4: Writable bits in word 0 follow mask 0x86DF81FD: enable bit 0, power mode 3:2, minus select 6:4, plus select 8:7, polarity 15, hysteresis 17:16, blanking select 20:18, bridge enable 22, scaler enable 23, extended minus select 26:25, lock 31. Each field appears on its matching output.
- R5: The window-mode bit (bit 9) exists only in word 1, whose writable mask is 0x86DF83FD. It drives window_mode. Bit 9 written to word 0 reads back 0.
- R6: After reset every word reads 0x00000000, apart from bit 30, which follows R3. Reserved bit positions always read 0.
- R7: The resolved minus source code equals the minus select (0..6) when the select is below 7. When the select is 7, the code is 7 + extended select (7..10). The extended select has no effect otherwise.
- R8: scaler_on is the OR of bit 23 over all words, and bridge_on is the OR of bit 22 over all words.
- R9: When scaler_on = 1 and bridge_on = 0, a minus select of 0, 1 or 2 (the quarter, half and three-quarter references) resolves to code 3 (the full reference).
- R10: An access hits channel ch only when bus_addr[1:0] = 0 and bus_addr[ADDR_W-1:2] = ch. Any other address reads 0 and a write to it changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmp_raw | input | NUM_CH | Raw comparator results |
| cmp_value | output | NUM_CH | Polarity-adjusted comparator results |
| ch_en | output | NUM_CH | Channel enables |
| ch_pwr_mode | output | 2*NUM_CH | Power/speed mode per channel |
| ch_plus_sel | output | 2*NUM_CH | Plus input select per channel |
| ch_minus_src | output | 4*NUM_CH | Resolved minus source code per channel |
| ch_hyst | output | 2*NUM_CH | Hysteresis select per channel |
| ch_blank_sel | output | 3*NUM_CH | Blanking source select per channel |
| window_mode | output | 1 | Plus inputs of channels 0 and 1 tied together |
| scaler_on | output | 1 | Shared reference scaler enabled |
| bridge_on | output | 1 | Shared scaler divider bridge enabled |

## Verification
The bench builds the block with NUM_CH = 2 and ADDR_W = 4. The wider address brings the unmapped word indices 2 and 3, as well as misaligned byte offsets, within reach of R10. With two channels the bench can sweep, for each channel, every minus select, every extended select and every scaler/bridge combination. It also places the scaler and bridge bits in the other channel's word to exercise the sharing rule. Expected readback values come from the masks written in the requirements, and the lock sequence is run on one word while the other word stays live.

// File: rtl/cmp_regs_pkg.sv
// Shared constants and types for the comparator control register file.
// Assumes 32-bit words; bit positions are fixed by the register layout.
package cmp_regs_pkg;
    localparam int WORD_W     = 32;
    localparam int LOCK_BIT   = 31;
    localparam int STATUS_BIT = 30;
    localparam int EXT_LO     = 25;
    localparam int SCALE_BIT  = 23;
    localparam int BRIDGE_BIT = 22;
    localparam int BLANK_LO   = 18;
    localparam int HYST_LO    = 16;
    localparam int POL_BIT    = 15;
    localparam int WIN_BIT    = 9;
    localparam int PLUS_LO    = 7;
    localparam int MINUS_LO   = 4;
    localparam int PWR_LO     = 2;
    localparam int EN_BIT     = 0;

    // Writable bits common to every channel word.
    localparam logic [WORD_W-1:0] BASE_MASK = 32'h86DF_81FD;
    // Extra writable bit held only by the second channel word.
    localparam logic [WORD_W-1:0] WIN_MASK  = 32'h0000_0200;

    // Resolved minus-input source codes.
    typedef enum logic [3:0] {
        SRC_QUARTER  = 4'd0,
        SRC_HALF     = 4'd1,
        SRC_THREEQ   = 4'd2,
        SRC_FULL     = 4'd3,
        SRC_DAC      = 4'd4,
        SRC_RSVD     = 4'd5,
        SRC_PIN      = 4'd6,
        SRC_EXT0     = 4'd7,
        SRC_EXT1     = 4'd8,
        SRC_EXT2     = 4'd9,
        SRC_EXT_RSVD = 4'd10
    } minus_src_e;
endpackage

// File: rtl/cmp_csr_word.sv
// One lockable configuration word.
// Holds only the bits in WMASK; others stay 0. Once bit 31 is stored,
// the word ignores writes until synchronous reset. Assumes wr_en is
// already address-decoded by the parent.
module cmp_csr_word
    import cmp_regs_pkg::*;
#(
    parameter logic [WORD_W-1:0] WMASK = BASE_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q
);
    logic locked;

    assign locked = word_q[LOCK_BIT];

    // Store masked write data unless the word is locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en && !locked) begin
            word_q <= wdata & WMASK;
        end
    end

    // R1: a locked word keeps its value on the next cycle
    assert_locked_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(word_q));

    // R2: the lock bit never falls outside reset
    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> word_q[LOCK_BIT]);
endmodule

// File: rtl/cmp_minus_decode.sv
// Resolves a channel's minus select into one source code.
// The extended select matters only for select 7; fractional references
// fall back to the full reference while the scaler runs without bridge.
module cmp_minus_decode
    import cmp_regs_pkg::*;
(
    input  logic [2:0] minus_sel,
    input  logic [1:0] ext_sel,
    input  logic       scaler_on,
    input  logic       bridge_on,
    output logic [3:0] src_code
);
    minus_src_e src;

    // Pick the source code from the select fields and shared enables.
    always_comb begin
        if (minus_sel == 3'd7) begin
            src = minus_src_e'(4'(SRC_EXT0) + {2'b00, ext_sel});
        end else if (scaler_on && !bridge_on && (minus_sel < 3'd3)) begin
            src = SRC_FULL;
        end else begin
            src = minus_src_e'({1'b0, minus_sel});
        end
    end

    assign src_code = 4'(src);
endmodule

// File: rtl/cmp_ctl_regs.sv
// Comparator control register file: NUM_CH lockable words at word
// offsets, combinational read, single-cycle write, decoded outputs.
// Assumes NUM_CH >= 2 (window bit lives in word 1) and ADDR_W large
// enough to index NUM_CH words.
module cmp_ctl_regs
    import cmp_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_CH-1:0]   cmp_raw,
    output logic [NUM_CH-1:0]   cmp_value,
    output logic [NUM_CH-1:0]   ch_en,
    output logic [2*NUM_CH-1:0] ch_pwr_mode,
    output logic [2*NUM_CH-1:0] ch_plus_sel,
    output logic [4*NUM_CH-1:0] ch_minus_src,
    output logic [2*NUM_CH-1:0] ch_hyst,
    output logic [3*NUM_CH-1:0] ch_blank_sel,
    output logic                window_mode,
    output logic                scaler_on,
    output logic                bridge_on
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  bus_idx;
    logic              aligned;
    logic [WORD_W-1:0] word_q [NUM_CH];
    logic [NUM_CH-1:0] wr_hit;
    logic [NUM_CH-1:0] rd_hit;

    assign bus_idx = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [WORD_W-1:0] MASK = (ch == 1) ? (BASE_MASK | WIN_MASK) : BASE_MASK;

        assign rd_hit[ch] = aligned && (bus_idx == IDX_W'(ch));
        assign wr_hit[ch] = bus_wr_en && rd_hit[ch];

        cmp_csr_word #(.WMASK(MASK)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_hit[ch]),
            .wdata  (bus_wdata),
            .word_q (word_q[ch])
        );

        assign cmp_value[ch]          = cmp_raw[ch] ^ word_q[ch][POL_BIT];
        assign ch_en[ch]              = word_q[ch][EN_BIT];
        assign ch_pwr_mode[2*ch +: 2] = word_q[ch][PWR_LO +: 2];
        assign ch_plus_sel[2*ch +: 2] = word_q[ch][PLUS_LO +: 2];
        assign ch_hyst[2*ch +: 2]     = word_q[ch][HYST_LO +: 2];
        assign ch_blank_sel[3*ch +: 3] = word_q[ch][BLANK_LO +: 3];

        cmp_minus_decode u_mdec (
            .minus_sel (word_q[ch][MINUS_LO +: 3]),
            .ext_sel   (word_q[ch][EXT_LO +: 2]),
            .scaler_on (scaler_on),
            .bridge_on (bridge_on),
            .src_code  (ch_minus_src[4*ch +: 4])
        );

        // R7: extended select cannot produce an extended code unless select is 7
        assert_ext_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (word_q[ch][MINUS_LO +: 3] != 3'd7) |-> (ch_minus_src[4*ch +: 4] < 4'd7));

        // R9: fractional requests get the full reference while bridge is off
        assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (scaler_on && !bridge_on && (word_q[ch][MINUS_LO +: 3] < 3'd3))
            |-> (ch_minus_src[4*ch +: 4] == 4'd3));
    end

    assign window_mode = word_q[1][WIN_BIT];

    // OR the shared scaler and bridge requests over all words.
    always_comb begin
        scaler_on = 1'b0;
        bridge_on = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            scaler_on = scaler_on | word_q[ch][SCALE_BIT];
            bridge_on = bridge_on | word_q[ch][BRIDGE_BIT];
        end
    end

    // Return the addressed word with the live status bit merged in.
    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_hit[ch]) begin
                bus_rdata = word_q[ch];
                bus_rdata[STATUS_BIT] = cmp_value[ch];
            end
        end
    end

    // R10: an address that hits no word reads zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/cmp_ctl_regs_tb.sv
module cmp_ctl_regs_tb;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 4;
    localparam logic [31:0] MASK0 = 32'h86DF_81FD;
    localparam logic [31:0] MASK1 = 32'h86DF_83FD;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr_en = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_CH-1:0]   cmp_raw = '0;
    logic [NUM_CH-1:0]   cmp_value;
    logic [NUM_CH-1:0]   ch_en;
    logic [2*NUM_CH-1:0] ch_pwr_mode;
    logic [2*NUM_CH-1:0] ch_plus_sel;
    logic [4*NUM_CH-1:0] ch_minus_src;
    logic [2*NUM_CH-1:0] ch_hyst;
    logic [3*NUM_CH-1:0] ch_blank_sel;
    logic                window_mode;
    logic                scaler_on;
    logic                bridge_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_ctl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .cmp_value(cmp_value), .ch_en(ch_en), .ch_pwr_mode(ch_pwr_mode),
        .ch_plus_sel(ch_plus_sel), .ch_minus_src(ch_minus_src), .ch_hyst(ch_hyst),
        .ch_blank_sel(ch_blank_sel), .window_mode(window_mode),
        .scaler_on(scaler_on), .bridge_on(bridge_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [3:0] exp_src(input int sel, input int ext, input bit sc, input bit br);
        if (sel == 7) return 4'(7 + ext);
        if (sc && !br && sel < 3) return 4'd3;
        return 4'(sel);
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        rd(4'h0, d); chk("R6 reset word0", d, 32'h0);
        rd(4'h4, d); chk("R6 reset word1", d, 32'h0);
        chk("R6 reset outputs", {ch_en, scaler_on, bridge_on, window_mode}, 0);

        // R4/R5/R6: all-ones readback follows masks (polarity set, raw 1 -> status 0)
        cmp_raw = 2'b11;
        wr(4'h0, 32'h7FFF_FFFF); rd(4'h0, d); chk("R4 mask word0", d, MASK0 & 32'h7FFF_FFFF);
        wr(4'h4, 32'h7FFF_FFFF); rd(4'h4, d); chk("R5 mask word1", d, MASK1 & 32'h7FFF_FFFF);
        chk("R5 window_mode on", window_mode, 1);

        // R4: field outputs with a mixed pattern on word1
        wr(4'h4, (32'd1 << 0) | (32'd2 << 2) | (32'd3 << 7) | (32'd1 << 16) | (32'd5 << 18));
        chk("R4 en", ch_en[1], 1);
        chk("R4 pwr", ch_pwr_mode[3:2], 2);
        chk("R4 plus", ch_plus_sel[3:2], 3);
        chk("R4 hyst", ch_hyst[3:2], 1);
        chk("R4 blank", ch_blank_sel[5:3], 5);
        chk("R5 window_mode off", window_mode, 0);

        // R3: status bit and cmp_value over raw x polarity, both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int raw = 0; raw < 2; raw++) begin
                    wr(4'(ch * 4), (32'(pol) << 15) | 32'h4000_0000);
                    cmp_raw[ch] = raw[0];
                    rd(4'(ch * 4), d);
                    chk("R3 status bit", d[30], 32'(raw ^ pol));
                    chk("R3 cmp_value", cmp_value[ch], 32'(raw ^ pol));
                    chk("R3 stored bits", d & ~32'h4000_0000, 32'(pol) << 15);
                end
            end
        end

        // R7/R9: sweep minus select, extended select and scaler/bridge
        for (int ch = 0; ch < 2; ch++) begin
            wr(4'((1 - ch) * 4), 32'h0);
            for (int sel = 0; sel < 8; sel++) begin
                for (int ext = 0; ext < 4; ext++) begin
                    for (int sb = 0; sb < 4; sb++) begin
                        wr(4'(ch * 4), (32'(ext) << 25) | (32'(sb >> 1) << 23) |
                                       (32'(sb & 1) << 22) | (32'(sel) << 4));
                        chk("R7 R9 minus source", ch_minus_src[4*ch +: 4],
                            exp_src(sel, ext, sb[1], sb[0]));
                        chk("R8 scaler/bridge", {scaler_on, bridge_on}, 32'(sb));
                    end
                end
            end
        end

        // R8: enables shared from the other word
        wr(4'h0, 32'd1 << 4);
        wr(4'h4, 32'd1 << 23);
        chk("R8 scaler from word1", scaler_on, 1);
        chk("R9 fallback via shared scaler", ch_minus_src[3:0], 3);
        wr(4'h0, (32'd1 << 4) | (32'd1 << 22));
        chk("R8 bridge from word0", bridge_on, 1);
        chk("R9 no fallback with bridge", ch_minus_src[3:0], 1);

        // R10: unmapped and misaligned addresses
        cmp_raw = 2'b00;
        wr(4'h0, 32'h0000_0005);
        wr(4'h4, 32'h0000_0009);
        wr(4'h8, 32'hFFFF_FFFF); wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h1, 32'h0000_00F1); wr(4'h6, 32'h0000_00F1);
        rd(4'h8, d); chk("R10 unmapped read 8", d, 0);
        rd(4'hC, d); chk("R10 unmapped read C", d, 0);
        rd(4'h2, d); chk("R10 misaligned read", d, 0);
        rd(4'h0, d); chk("R10 word0 untouched", d, 32'h5);
        rd(4'h4, d); chk("R10 word1 untouched", d, 32'h9);

        // R1/R2: lock word0
        wr(4'h0, 32'h8000_0011);
        wr(4'h0, 32'h0000_0000);
        rd(4'h0, d); chk("R1 locked write ignored", d, 32'h8000_0011);
        wr(4'h0, 32'h7FFF_FFFF);
        rd(4'h0, d); chk("R2 lock not cleared by write", d, 32'h8000_0011);
        chk("R1 outputs frozen", ch_minus_src[3:0], 1);
        cmp_raw = 2'b01;
        rd(4'h0, d); chk("R1 read still live", d, 32'hC000_0011);
        wr(4'h4, 32'h0000_0001);
        rd(4'h4, d); chk("R1 other word writable", d, 32'h1);

        // R2/R6: reset clears lock
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        cmp_raw = 2'b00;
        rd(4'h0, d); chk("R2 reset unlocks", d, 0);
        wr(4'h0, 32'h0000_0003);
        rd(4'h0, d); chk("R2 writable after reset", d, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule